// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave end of a two-wire serial memory holding 2,048 bytes. A fast system clock samples the bus clock and data lines through short synchronisers. The block answers by pulling the data line low through an open-drain enable; it never drives the line high. It recognises bus start and stop conditions and decodes a control byte. That byte carries a fixed device-type nibble, three page-select bits that form the upper address bits, and a read/write flag.

Writes load a low address byte and then fill a sixteen-byte page buffer. The buffer reaches the storage array only when the master closes the write with a stop. Reads shift out bytes from an address counter that lives across transactions, so current-address, random and sequential reads all come from the same mechanism. A write-protect input blocks every write to the whole array.

Top module: `eep_slave`

## Requirements
- R1: After reset, and until a start condition (data falls while clock is high) is seen, the block ignores all bus activity and keeps `sda_oe_o` low.
- R2: A stop condition (data rises while clock is high) ends the transaction; bytes clocked after it are not acknowledged.
- R3: Write data reaches the array only when a stop ends the write; a repeated start discards the buffered bytes and leaves the array unchanged.
- R4: A control byte whose upper four bits differ from 4'b1010 is not acknowledged, and the block ignores the bus until the next start.
- R5: Control-byte bits [3:1] become address bits [10:8] of the write address (000 selects 0x000–0x0FF, 111 selects 0x700–0x7FF).
- R6: Control-byte bit 0 selects read (1) or write (0), and both forms of a valid control byte are acknowledged.
- R7: While `wp_i` is high, the control and address bytes are acknowledged but data bytes are not, and the array is unchanged after the stop.
- R8: The block samples data on the clock rising edge, changes `sda_oe_o` only while the clock is low, and acknowledges a received byte by pulling data low during the ninth clock.
- R9: In a write, the byte after the control byte sets address bits [7:0]; each data byte then advances only address bits [3:0], wrapping inside its sixteen-byte page.
- R10: A read returns the byte at the current address MSB first, then increments the full 11-bit address, wrapping from 0x7FF to 0x000.
- R11: A not-acknowledge from the master after a read byte ends the output; the block stays released until the next start.
- R12: The address counter persists between transactions, so a read with no address phase continues at the location after the last one accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| wp_i | input | 1 | Write protect for the whole array, active high |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |

## Verification
The hardest case to reach from the ports is a write cut short by a repeated start. The page buffer then holds valid bytes, yet the array must keep its old contents. The bench first commits a known byte, reopens a write to the same location with different data, and issues a start and a stop with no stop ending the data phase. A random read then shows the old byte. Page-wrap writes, a protected write to the same location, and a sequential read across 0x7FF are driven as directed cases. Random page writes and reads of random length follow, all checked against a byte-level model with a known-location mask.

// File: rtl/eep_pkg.sv
// Package: shared types for the two-wire EEPROM slave.
// Assumes: one bus transaction is in flight at a time.
package eep_pkg;

    // Byte-level phase of the slave engine
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CTRL  = 3'd1,
        ST_ADDR  = 3'd2,
        ST_WDATA = 3'd3,
        ST_RDATA = 3'd4
    } eep_state_e;

    // Fixed device-type nibble carried in the control byte
    localparam logic [3:0] DEV_ID = 4'b1010;

endpackage

// File: rtl/eep_line_sync.sv
// Module: eep_line_sync
// Brings the bus clock and data lines into the system clock domain and
// derives clock edges plus start and stop conditions from them.
// Assumes: the system clock runs several times faster than the bus clock,
// and the idle bus level is high.
module eep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    localparam int PW = STAGES + 1;

    logic [PW-1:0] scl_pipe;
    logic [PW-1:0] sda_pipe;

    // Shift both lines through the synchroniser plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PW-2:0], scl_i};
            sda_pipe <= {sda_pipe[PW-2:0], sda_i};
        end
    end

    logic scl_q;
    logic sda_q;

    // Condition detection from the current and previous synchronised level
    always_comb begin
        scl_s    = scl_pipe[STAGES-1];
        sda_s    = sda_pipe[STAGES-1];
        scl_q    = scl_pipe[STAGES];
        sda_q    = sda_pipe[STAGES];
        scl_rise = scl_s & ~scl_q;
        scl_fall = ~scl_s & scl_q;
        start_c  = scl_s & scl_q & sda_q & ~sda_s;
        stop_c   = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/eep_store.sv
// Module: eep_store
// Storage array with a page buffer in front of it. Buffered bytes are
// copied into the array one per cycle after a commit request.
// Assumes: commit takes PSIZE cycles, far shorter than one bus bit time.
module eep_store #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_we,
    input  logic [PAGE_W-1:0] buf_idx,
    input  logic [7:0]        buf_data,
    input  logic              buf_clr,
    input  logic              commit,
    input  logic [ADDR_W-PAGE_W-1:0] commit_base,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PSIZE = 1 << PAGE_W;
    localparam int BW    = ADDR_W - PAGE_W;

    logic [7:0]        mem_q  [DEPTH];
    logic [7:0]        pbuf_q [PSIZE];
    logic [PSIZE-1:0]  valid_q;
    logic [PAGE_W-1:0] idx_q;
    logic [BW-1:0]     base_q;
    logic              busy_q;
    logic              wr_en;

    assign wr_en   = busy_q & valid_q[idx_q];
    assign rd_data = mem_q[rd_addr];
    assign busy    = busy_q;

    // Page buffer data bytes, one per accepted bus byte
    always_ff @(posedge clk) begin
        if (buf_we) pbuf_q[buf_idx] <= buf_data;
    end

    // Array write port driven by the commit walk
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[{base_q, idx_q}] <= pbuf_q[idx_q];
    end

    // Valid mask and commit walk over the page buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            idx_q   <= '0;
            base_q  <= '0;
            busy_q  <= 1'b0;
        end else if (busy_q) begin
            valid_q[idx_q] <= 1'b0;
            idx_q          <= idx_q + 1'b1;
            if (idx_q == PAGE_W'(PSIZE - 1)) busy_q <= 1'b0;
        end else if (commit) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
            base_q <= commit_base;
        end else if (buf_clr) begin
            valid_q <= '0;
        end else if (buf_we) begin
            valid_q[buf_idx] <= 1'b1;
        end
    end

endmodule

// File: rtl/eep_slave.sv
// Module: eep_slave (top)
// Two-wire serial EEPROM slave: decodes control and address bytes, buffers
// page writes until a stop, serves reads from a persistent address counter.
// Assumes: ADDR_W - 8 equals the width of the control-byte page field (3).
module eep_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe_o
);
    localparam int HI_W = ADDR_W - 8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

    eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    eep_state_e        state_q, after_q;
    logic [3:0]        bitcnt_q;
    logic [7:0]        shreg_q;
    logic              sda_oe_q;
    logic [ADDR_W-1:0] addr_q;
    logic [HI_W-1:0]   page_q;
    logic [7:0]        rd_data;
    logic              busy;
    logic              buf_we, commit;

    // Accept a data byte into the page buffer at its ack decision
    assign buf_we = (state_q == ST_WDATA) && scl_fall && (bitcnt_q == 4'd8) && !wp_i;
    // Commit only when a stop closes an unprotected write
    assign commit = stop_c && (state_q == ST_WDATA) && !wp_i;
    assign sda_oe_o = sda_oe_q;

    eep_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .buf_we      (buf_we),
        .buf_idx     (addr_q[PAGE_W-1:0]),
        .buf_data    (shreg_q),
        .buf_clr     (start_c),
        .commit      (commit),
        .commit_base (addr_q[ADDR_W-1:PAGE_W]),
        .rd_addr     (addr_q),
        .rd_data     (rd_data),
        .busy        (busy)
    );

    // Bit and byte sequencing of the slave engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            after_q  <= ST_IDLE;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            sda_oe_q <= 1'b0;
            addr_q   <= '0;
            page_q   <= '0;
        end else if (start_c) begin
            state_q  <= ST_CTRL;
            bitcnt_q <= '0;
            sda_oe_q <= 1'b0;
        end else if (stop_c) begin
            state_q  <= ST_IDLE;
            bitcnt_q <= '0;
            sda_oe_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: ;
                ST_CTRL, ST_ADDR, ST_WDATA: begin
                    if (scl_rise && bitcnt_q < 4'd8) begin
                        shreg_q  <= {shreg_q[6:0], sda_s};
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end else if (scl_fall && bitcnt_q == 4'd8) begin
                        bitcnt_q <= 4'd9;
                        sda_oe_q <= 1'b1;
                        if (state_q == ST_CTRL) begin
                            if (shreg_q[7:4] != DEV_ID) begin
                                state_q  <= ST_IDLE;
                                sda_oe_q <= 1'b0;
                                bitcnt_q <= '0;
                            end else if (shreg_q[0]) begin
                                after_q <= ST_RDATA;
                            end else begin
                                after_q <= ST_ADDR;
                                page_q  <= shreg_q[HI_W:1];
                            end
                        end else if (state_q == ST_ADDR) begin
                            addr_q  <= {page_q, shreg_q};
                            after_q <= ST_WDATA;
                        end else if (wp_i) begin
                            state_q  <= ST_IDLE;
                            sda_oe_q <= 1'b0;
                            bitcnt_q <= '0;
                        end else begin
                            addr_q  <= {addr_q[ADDR_W-1:PAGE_W],
                                        PAGE_W'(addr_q[PAGE_W-1:0] + 1'b1)};
                            after_q <= ST_WDATA;
                        end
                    end else if (scl_fall && bitcnt_q == 4'd9) begin
                        bitcnt_q <= '0;
                        state_q  <= after_q;
                        if (after_q == ST_RDATA) begin
                            shreg_q  <= rd_data;
                            sda_oe_q <= ~rd_data[7];
                        end else begin
                            sda_oe_q <= 1'b0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_rise && bitcnt_q < 4'd8) begin
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end else if (scl_fall && bitcnt_q != 4'd0 && bitcnt_q < 4'd8) begin
                        shreg_q  <= {shreg_q[6:0], 1'b0};
                        sda_oe_q <= ~shreg_q[6];
                    end else if (scl_fall && bitcnt_q == 4'd8) begin
                        sda_oe_q <= 1'b0;
                        addr_q   <= addr_q + 1'b1;
                    end else if (scl_rise && bitcnt_q == 4'd8) begin
                        if (sda_s) begin
                            state_q  <= ST_IDLE;
                            bitcnt_q <= '0;
                        end else begin
                            bitcnt_q <= 4'd9;
                        end
                    end else if (scl_fall && bitcnt_q == 4'd9) begin
                        bitcnt_q <= '0;
                        shreg_q  <= rd_data;
                        sda_oe_q <= ~rd_data[7];
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eep_slave_chk.sv
// Module: eep_slave_chk
// Protocol properties of eep_slave, attached to every instance by bind.
// Assumes: the bus clock is held low for several system clocks.
module eep_slave_chk
    import eep_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wp_i,
    input logic       sda_oe_o,
    input logic       scl_s,
    input logic       scl_fall,
    input eep_state_e state_q,
    input logic [3:0] bitcnt_q,
    input logic [7:0] shreg_q,
    input logic       busy
);
    // R1: released whenever the engine is idle
    p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe_o);

    // R8: the data line enable moves only while the bus clock is low
    p_sda_moves_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_s);

    // R4: a wrong device nibble is never acknowledged
    p_ack_bad_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CTRL && bitcnt_q == 4'd8 && scl_fall && shreg_q[7:4] != DEV_ID)
        |=> !sda_oe_o);

    // R7: a commit walk never starts while protected
    p_commit_unprotected_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp_i));

endmodule

bind eep_slave eep_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_i     (wp_i),
    .sda_oe_o (sda_oe_o),
    .scl_s    (scl_s),
    .scl_fall (scl_fall),
    .state_q  (state_q),
    .bitcnt_q (bitcnt_q),
    .shreg_q  (shreg_q),
    .busy     (busy)
);

// File: tb/eep_slave_tb_top.sv
// Bench for eep_slave: bus master tasks, byte model with known-location
// mask, directed corner cases followed by seeded random transactions.
module eep_slave_tb_top;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int fails = 0;
    logic [7:0] mdl [2048];
    bit known [2048];
    logic [10:0] cur = '0;
    bit cur_ok = 1'b0;

    always #4 clk = ~clk;
    assign sda_line = m_sda & ~sda_oe;

    eep_slave dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] page_addr(input logic [10:0] a, input int i);
        return {a[10:4], 4'(a[3:0] + i)};
    endfunction

    task automatic i2c_start();
        m_sda = 1'b1; wt(Q); scl = 1'b1; wt(2*Q);
        m_sda = 1'b0; wt(2*Q); scl = 1'b0; wt(Q);
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; wt(Q); scl = 1'b1; wt(2*Q);
        m_sda = 1'b1; wt(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
        end
        m_sda = 1'b1; wt(Q); scl = 1'b1; wt(Q);
        ack = (sda_line == 1'b0);
        wt(Q); scl = 1'b0; wt(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(Q); scl = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl = 1'b0;
        end
        wt(Q); m_sda = give_ack ? 1'b0 : 1'b1;
        wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q); m_sda = 1'b1;
    endtask

    // Compare n read bytes starting at a against the model
    task automatic read_burst(input logic [10:0] a, input int n, input string req);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            logic [10:0] ea;
            ea = a + 11'(i);
            recv_byte(i != n - 1, b);
            if (known[ea]) chk(b == mdl[ea], req, b, mdl[ea]);
        end
        cur = a + 11'(n);
        cur_ok = 1'b1;
    endtask

    task automatic do_write(input logic [10:0] a, input int n, input bit wpv);
        logic [7:0] d [20];
        bit ack;
        wp = wpv;
        i2c_start();
        send_byte({4'b1010, a[10:8], 1'b0}, ack);
        chk(ack, "R6 write control ack", ack, 1);
        send_byte(a[7:0], ack);
        chk(ack, "R8 address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            d[i] = 8'($urandom);
            send_byte(d[i], ack);
            chk(ack == !wpv, "R7 data ack vs protect", ack, !wpv);
            if (!ack) break;
        end
        i2c_stop();
        wt(40);
        wp = 1'b0;
        if (!wpv) begin
            for (int i = 0; i < n; i++) begin
                mdl[page_addr(a, i)] = d[i];
                known[page_addr(a, i)] = 1'b1;
            end
            cur = page_addr(a, n);
        end else begin
            cur = a;
        end
        cur_ok = 1'b1;
    endtask

    task automatic do_rread(input logic [10:0] a, input int n, input string req);
        bit ack;
        i2c_start();
        send_byte({4'b1010, a[10:8], 1'b0}, ack);
        chk(ack, "R6 dummy write ack", ack, 1);
        send_byte(a[7:0], ack);
        chk(ack, "R9 address ack", ack, 1);
        i2c_start();
        send_byte({4'b1010, 3'($urandom), 1'b1}, ack);
        chk(ack, "R6 read control ack", ack, 1);
        read_burst(a, n, req);
        i2c_stop();
        wt(8);
    endtask

    task automatic do_cread(input int n);
        bit ack;
        i2c_start();
        send_byte({4'b1010, 3'($urandom), 1'b1}, ack);
        chk(ack, "R12 current read ack", ack, 1);
        read_burst(cur, n, "R12 current address read");
        i2c_stop();
        wt(8);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        wt(190000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit ack;
        logic [7:0] b;
        void'($urandom(32'h1C3D));
        for (int i = 0; i < 2048; i++) known[i] = 1'b0;
        wt(5);
        rst_n = 1'b1;
        wt(5);
        chk(sda_oe == 1'b0, "R1 released after reset", sda_oe, 0);

        // R1: a byte clocked with no prior start is ignored
        send_byte(8'hA0, ack);
        chk(!ack, "R1 no ack before start", ack, 0);
        i2c_stop();

        // R4: wrong device type, then bytes without a new start
        i2c_start();
        send_byte(8'hB0, ack);
        chk(!ack, "R4 bad device type nack", ack, 0);
        send_byte(8'hA0, ack);
        chk(!ack, "R4 ignored until next start", ack, 0);
        i2c_stop();

        // R5 R9: page 7 write starting at 0xFE wraps inside its page
        do_write(11'h7FE, 4, 1'b0);
        do_rread(11'h7F0, 2, "R9 page wrap low bytes");
        do_rread(11'h7FE, 2, "R5 page select high bytes");
        chk(known[11'h7F1] && !known[11'h700], "R9 wrap stays in page", known[11'h7F1], 1);

        // R10: sequential read across the top of the array
        do_write(11'h000, 1, 1'b0);
        do_rread(11'h7FF, 2, "R10 wrap 0x7FF to 0x000");

        // R12: current-address read continues after the last read
        do_cread(2);

        // R3: committed byte survives a write aborted by repeated start
        wp = 1'b0;
        i2c_start(); send_byte(8'hA2, ack); send_byte(8'h23, ack);
        send_byte(8'h5A, ack); i2c_stop(); wt(40);
        mdl[11'h123] = 8'h5A; known[11'h123] = 1'b1;
        i2c_start(); send_byte(8'hA2, ack); send_byte(8'h23, ack);
        send_byte(8'hC3, ack);
        i2c_start(); i2c_stop(); wt(40);
        do_rread(11'h123, 1, "R3 repeated start discards buffer");

        // R7: protected write leaves the byte unchanged
        do_write(11'h123, 2, 1'b1);
        do_rread(11'h123, 1, "R7 protected array unchanged");

        // R11: after a NACK the slave stays released
        i2c_start(); send_byte(8'hA2, ack); send_byte(8'h23, ack);
        i2c_start(); send_byte(8'hA3, ack);
        recv_byte(1'b0, b);
        chk(b == 8'h5A, "R10 MSB-first read data", b, 8'h5A);
        recv_byte(1'b0, b);
        chk(b == 8'hFF, "R11 no output after nack", b, 8'hFF);
        i2c_stop();
        cur = 11'h124;

        // R2: after a stop, bytes get no acknowledge
        send_byte(8'hA0, ack);
        chk(!ack, "R2 no ack after stop", ack, 0);
        i2c_stop();

        // Seeded random mix of writes and reads
        for (int t = 0; t < 24; t++) begin
            int op;
            logic [10:0] a;
            op = $urandom_range(0, 5);
            a = 11'($urandom);
            if (op <= 1)      do_write(a, $urandom_range(1, 18), 1'b0);
            else if (op == 2) do_write(a, $urandom_range(1, 3), ($urandom_range(0, 3) == 0));
            else if (op <= 4) do_rread(a, $urandom_range(1, 8), "R10 random sequential read");
            else              do_cread($urandom_range(1, 6));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule